// File: doc/BRIEF.md
# Instruction Fetch Sequencer

This block reads a program one byte at a time from a memory port and builds whole instructions for an execute stage. The first byte of each instruction is its opcode. The opcode decides whether the instruction is one byte long, two bytes long (an 8-bit immediate follows), or three bytes long (a 16-bit target address follows, low byte first). A finished instruction is handed over on a valid/ready channel together with the address of its opcode. A 16-bit program counter advances by one for every byte read. An external redirect loads a new counter value and drops any instruction that is only partly collected.

Three opcode values stop the machine: 0xFF, and the aliases 0x00 and 0x01. The aliases are there so that a program counter running into empty or erased memory parks instead of running on. After a stop the block issues no more reads and keeps its stop flag set until synchronous reset.

The memory port has a fixed latency of one cycle. A byte requested with `mem_rd` in cycle t appears on `mem_rdata` in cycle t+1. Back-pressure on the instruction channel works like this: while `ins_valid` is high and `ins_ready` is low, the presented instruction is frozen. The sequencer also stops issuing any read whose returning byte would complete another instruction, so no byte is ever lost and no skid storage is needed.

Top module: `insn_fetch_seq`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), `mem_rd` is 0. After reset, `ins_valid` and `halted` are 0 and the first read is at address 0x0040 (the `RESET_PC` default).
- R2: Reads run through consecutive addresses. After every read, `mem_addr` in the next cycle is one higher, unless a redirect intervenes.
- R3: Length comes from the opcode. Top bits 01 with bit 0 clear gives 3 bytes. Top bits 01 with bit 0 set gives 1 byte. Top bits 00 with low three bits 100 or 110 gives 2 bytes. Everything else gives 1 byte. `ins_len` reports 1, 2 or 3.
- R4: `ins_arg_lo` carries the second byte and `ins_arg_hi` carries the third byte. Operand fields that the instruction does not use read 0. `ins_pc` is the opcode's address. Instructions arrive in program order, with none missing or extra.
- R5: An opcode of 0xFF, 0x00 or 0x01 produces no instruction. No read is issued from the cycle that byte arrives, and `halted` rises in the following cycle.
- R6: The values 0x00, 0x01 and 0xFF in operand positions are plain data and do not stop the block.
- R7: While `ins_valid` is high and `ins_ready` is low, `ins_valid` stays high and every instruction field stays unchanged.
- R8: When the output is held by back-pressure, reads stop before a byte that could complete another instruction. That instruction is delivered later, intact.
- R9: A redirect issues no read in its own cycle and drops the byte arriving in that cycle along with any partial instruction. The next read is at `redirect_pc`.
- R10: Once halted, a redirect has no effect: no reads, `mem_addr` unchanged, and `halted` stays high until reset.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rd | output | 1 | Byte read request this cycle |
| mem_addr | output | ADDR_W | Read address (program counter) |
| mem_rdata | input | 8 | Byte returned one cycle after the request |
| redirect_valid | input | 1 | Load a new program counter |
| redirect_pc | input | ADDR_W | New program counter value |
| ins_valid | output | 1 | Assembled instruction present |
| ins_ready | input | 1 | Execute stage accepts the instruction |
| ins_opcode | output | 8 | Opcode byte |
| ins_arg_lo | output | 8 | Second byte (immediate or address low) |
| ins_arg_hi | output | 8 | Third byte (address high) |
| ins_len | output | 2 | Instruction length in bytes |
| ins_pc | output | ADDR_W | Address of the opcode |
| halted | output | 1 | Stop opcode seen; fetching frozen |

## Verification
The main program mixes all three lengths and places stop-like values (0x00, 0x01, 0xFF) in operand slots, so a wrong length rule or operand-position halt detection shows up as a missing, shifted or truncated instruction. The same program runs with the ready input always high, toggling, and held low for a long stretch. These three runs separate correct back-pressure from lost or duplicated bytes and from reads that continue while the output is blocked. Separate programs end on each of the three stop codes, which checks each alias and the exact cycle `halted` rises. A redirect placed between an opcode and its address bytes, and another issued after a stop, show that partial work is dropped and that the stop cannot be undone without reset.

// File: rtl/insn_fetch_pkg.sv
package insn_fetch_pkg;
  localparam int OPW = 8;
  typedef logic [OPW-1:0] byte_t;
  typedef logic [1:0]     ilen_t;

  localparam byte_t STOP_MAIN = 8'hFF;
  localparam byte_t STOP_ZERO = 8'h00;
  localparam byte_t STOP_ONE  = 8'h01;

  typedef struct packed {
    byte_t opcode;
    byte_t arg_lo;
    byte_t arg_hi;
    ilen_t len;
  } ins_t;
endpackage

// File: rtl/insn_len_dec.sv
module insn_len_dec
  import insn_fetch_pkg::*;
#(
  parameter bit HALT_ALIASES = 1'b1
) (
  input  byte_t code,
  output ilen_t len,
  output logic  halt
);
  // Length rule: class is bits [7:6], low field is bits [2:0]
  always_comb begin
    unique case (code[7:6])
      2'b01:   len = code[0] ? 2'd1 : 2'd3;
      2'b00:   len = (code[2:0] == 3'b100 || code[2:0] == 3'b110) ? 2'd2 : 2'd1;
      default: len = 2'd1;
    endcase
  end

  generate
    if (HALT_ALIASES) begin : g_alias
      assign halt = (code == STOP_MAIN) || (code == STOP_ZERO) || (code == STOP_ONE);
    end else begin : g_single
      assign halt = (code == STOP_MAIN);
    end
  endgenerate
endmodule

// File: rtl/insn_pc_ctr.sv
module insn_pc_ctr #(
  parameter int ADDR_W = 16,
  parameter int unsigned RESET_PC = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] PC0 = ADDR_W'(RESET_PC);

  always_ff @(posedge clk) begin
    if (!rst_n)    pc <= PC0;
    else if (load) pc <= load_val;
    else if (step) pc <= pc + ADDR_W'(1);
  end
endmodule

// File: rtl/insn_out_stage.sv
module insn_out_stage
  import insn_fetch_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  ins_t              d,
  input  logic [ADDR_W-1:0] d_pc,
  output logic              valid,
  input  logic              ready,
  output ins_t              q,
  output logic [ADDR_W-1:0] q_pc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
      q_pc  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      q     <= d;
      q_pc  <= d_pc;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R7: a stalled instruction stays put
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(q) && $stable(q_pc));

  // R8: the sequencer never completes an instruction into an occupied slot
  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!valid || ready));
endmodule

// File: rtl/insn_fetch_seq.sv
module insn_fetch_seq
  import insn_fetch_pkg::*;
#(
  parameter int          ADDR_W       = 16,
  parameter int unsigned RESET_PC     = 'h40,
  parameter bit          HALT_ALIASES = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_pc,
  output logic              ins_valid,
  input  logic              ins_ready,
  output logic [7:0]        ins_opcode,
  output logic [7:0]        ins_arg_lo,
  output logic [7:0]        ins_arg_hi,
  output logic [1:0]        ins_len,
  output logic [ADDR_W-1:0] ins_pc,
  output logic              halted
);
  logic              pend_q;
  logic [1:0]        cnt_q, cnt_n;
  ilen_t             need_q, need_n;
  byte_t             opc_q, lo_q;
  logic [ADDR_W-1:0] pc, ipc_q, nxt_pc;
  logic              halted_q;
  ilen_t             dlen;
  logic              dhalt;
  logic              arrive, at_op, halt_now, complete, busy_n, mid_safe;
  ins_t              nxt, outq;

  insn_len_dec #(.HALT_ALIASES(HALT_ALIASES)) u_dec (
    .code (mem_rdata),
    .len  (dlen),
    .halt (dhalt)
  );

  insn_pc_ctr #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (redirect_valid && !halted_q),
    .load_val (redirect_pc),
    .step     (mem_rd),
    .pc       (pc)
  );

  assign arrive   = pend_q && !redirect_valid;
  assign at_op    = (cnt_q == 2'd0);
  assign halt_now = arrive && at_op && dhalt;

  // Byte collection: which slot the arriving byte fills and whether it ends the instruction
  always_comb begin
    cnt_n    = cnt_q;
    need_n   = need_q;
    complete = 1'b0;
    if (redirect_valid) begin
      cnt_n = 2'd0;
    end else if (arrive) begin
      unique case (cnt_q)
        2'd0: begin
          if (dhalt) begin
            cnt_n = 2'd0;
          end else if (dlen == 2'd1) begin
            cnt_n    = 2'd0;
            complete = 1'b1;
          end else begin
            cnt_n  = 2'd1;
            need_n = dlen;
          end
        end
        2'd1: begin
          if (need_q == 2'd2) begin
            cnt_n    = 2'd0;
            complete = 1'b1;
          end else begin
            cnt_n = 2'd2;
          end
        end
        default: begin
          cnt_n    = 2'd0;
          complete = 1'b1;
        end
      endcase
    end
  end

  // Next byte is a guaranteed middle operand, so it can never need the output slot
  assign mid_safe = (cnt_n == 2'd1) && (need_n == 2'd3);
  assign busy_n   = complete || (ins_valid && !ins_ready);
  assign mem_rd   = rst_n && !halted_q && !halt_now && !redirect_valid && (mid_safe || !busy_n);
  assign mem_addr = pc;

  always_comb begin
    nxt.opcode = at_op ? mem_rdata : opc_q;
    nxt.arg_lo = (cnt_q == 2'd1) ? mem_rdata : ((cnt_q == 2'd2) ? lo_q : '0);
    nxt.arg_hi = (cnt_q == 2'd2) ? mem_rdata : '0;
    nxt.len    = at_op ? dlen : need_q;
    nxt_pc     = at_op ? (pc - ADDR_W'(1)) : ipc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      cnt_q    <= 2'd0;
      need_q   <= 2'd0;
      opc_q    <= '0;
      lo_q     <= '0;
      ipc_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      pend_q <= mem_rd;
      cnt_q  <= cnt_n;
      need_q <= need_n;
      if (arrive && at_op) begin
        opc_q <= mem_rdata;
        ipc_q <= pc - ADDR_W'(1);
      end
      if (arrive && cnt_q == 2'd1) lo_q <= mem_rdata;
      if (halt_now) halted_q <= 1'b1;
    end
  end

  insn_out_stage #(.ADDR_W(ADDR_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (complete),
    .d     (nxt),
    .d_pc  (nxt_pc),
    .valid (ins_valid),
    .ready (ins_ready),
    .q     (outq),
    .q_pc  (ins_pc)
  );

  assign ins_opcode = outq.opcode;
  assign ins_arg_lo = outq.arg_lo;
  assign ins_arg_hi = outq.arg_hi;
  assign ins_len    = outq.len;
  assign halted     = halted_q;

  // R2: each read moves the address on by one
  assert_read_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_addr == $past(mem_addr) + ADDR_W'(1));

  // R9: a redirect reads nothing in its own cycle and targets the new address next
  assert_redirect_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> !mem_rd);
  assert_redirect_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid && !halted |=> mem_addr == $past(redirect_pc));

  // R5: a stopped sequencer issues no reads
  assert_no_read_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_rd);

  // R10: only reset leaves the stopped state, and the address is frozen
  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(mem_addr));
endmodule

// File: tb/insn_fetch_seq_tb.sv
module insn_fetch_seq_tb;
  logic        clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        redirect_valid = 1'b0;
  logic [15:0] redirect_pc = '0;
  logic        ins_valid;
  logic        ins_ready = 1'b0;
  logic [7:0]  ins_opcode, ins_arg_lo, ins_arg_hi;
  logic [1:0]  ins_len;
  logic [15:0] ins_pc;
  logic        halted;

  insn_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_opcode(ins_opcode),
    .ins_arg_lo(ins_arg_lo), .ins_arg_hi(ins_arg_hi), .ins_len(ins_len),
    .ins_pc(ins_pc), .halted(halted)
  );

  logic [7:0] mem [256];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  typedef struct { int op; int lo; int hi; int len; int pc; } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0, cyc = 0;
  int exp_rd, halt_addr, hc, rdy_mode, low_until, redir_trig, redir_tgt;
  bit halt_seen, redir_pend, rst_drive;
  bit pv, pr;
  logic [47:0] pfields;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int blen(input int op);
    if ((op >> 6) == 1) return (op & 1) ? 1 : 3;
    if ((op >> 6) == 0 && ((op & 7) == 4 || (op & 7) == 6)) return 2;
    return 1;
  endfunction

  function automatic bit is_stop(input int op);
    return op == 255 || op == 0 || op == 1;
  endfunction

  task automatic build(input int start, input int limit);
    int a = start;
    int n = 0;
    while (1) begin
      int op = int'(mem[a & 255]);
      int l;
      exp_t e;
      if (is_stop(op)) begin halt_addr = a; return; end
      if (n == limit) return;
      l = blen(op);
      e.op = op; e.len = l; e.pc = a;
      e.lo = (l > 1) ? int'(mem[(a + 1) & 255]) : 0;
      e.hi = (l > 2) ? int'(mem[(a + 2) & 255]) : 0;
      q.push_back(e);
      a += l; n++;
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    rst_n = rst_drive;
    case (rdy_mode)
      0: ins_ready = 1'b1;
      1: ins_ready = (cyc % 3) != 0;
      default: ins_ready = (cyc >= low_until);
    endcase
    redirect_valid = redir_pend;
    redirect_pc = 16'(redir_tgt);
    #3;
    if (!rst_n) begin
      chk(mem_rd == 1'b0, "R1 no read in reset", int'(mem_rd), 0);
      return;
    end
    if (redirect_valid) begin
      chk(!mem_rd, "R9 no read on redirect", int'(mem_rd), 0);
      if (!halted) exp_rd = redir_tgt;
      redir_pend = 1'b0;
    end
    if (halt_seen) begin
      hc++;
      chk(halted == (hc >= 2), "R5 halted timing", int'(halted), int'(hc >= 2));
    end
    if (mem_rd) begin
      if (halt_seen) chk(1'b0, "R5 read after stop", int'(mem_addr), 0);
      else begin
        chk(int'(mem_addr) == exp_rd, "R2 read address", int'(mem_addr), exp_rd);
        if (int'(mem_addr) == halt_addr) begin halt_seen = 1'b1; hc = 0; end
        if (int'(mem_addr) == redir_trig) redir_pend = 1'b1;
        exp_rd++;
      end
    end
    if (pv && !pr)
      chk(ins_valid && {ins_opcode, ins_arg_lo, ins_arg_hi, 6'(ins_len), ins_pc} == pfields,
          "R7 held under back-pressure", int'(ins_opcode), int'(pfields[47:40]));
    if (ins_valid && ins_ready) begin
      if (q.size() == 0) chk(1'b0, "R4 unexpected instruction", int'(ins_opcode), 0);
      else begin
        exp_t e = q.pop_front();
        chk(int'(ins_opcode) == e.op, "R4 opcode", int'(ins_opcode), e.op);
        chk(int'(ins_len) == e.len, "R3 length", int'(ins_len), e.len);
        chk(int'(ins_arg_lo) == e.lo, "R4 operand low", int'(ins_arg_lo), e.lo);
        chk(int'(ins_arg_hi) == e.hi, "R4 operand high", int'(ins_arg_hi), e.hi);
        chk(int'(ins_pc) == e.pc, "R4 opcode address", int'(ins_pc), e.pc);
      end
    end
    pv = ins_valid; pr = ins_ready;
    pfields = {ins_opcode, ins_arg_lo, ins_arg_hi, 6'(ins_len), ins_pc};
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
  endtask

  task automatic do_reset();
    rst_drive = 1'b0; redir_pend = 1'b0; redir_trig = -1;
    step(); step(); step();
    chk(!ins_valid && !halted, "R1 reset state", int'({ins_valid, halted}), 0);
    q.delete();
    exp_rd = 'h40; halt_addr = -1; halt_seen = 1'b0; hc = 0; pv = 1'b0; pr = 1'b0;
    rst_drive = 1'b1;
  endtask

  task automatic run(input int max);
    int n = 0;
    while (!(halt_seen && hc >= 4) && n < max) begin step(); n++; end
    chk(n < max, "R5 program reached stop", n, max);
    chk(q.size() == 0, "R4 all instructions delivered", q.size(), 0);
    chk(halted == 1'b1, "R5 halted asserted", int'(halted), 1);
  endtask

  task automatic load_main();
    clear_mem();
    mem['h40] = 8'hC0;
    mem['h41] = 8'h06; mem['h42] = 8'h00;                   // R6 zero operand
    mem['h43] = 8'h44; mem['h44] = 8'h34; mem['h45] = 8'h12;
    mem['h46] = 8'h80;
    mem['h47] = 8'h46; mem['h48] = 8'hFF; mem['h49] = 8'h01; // R6 stop values as data
    mem['h4A] = 8'h04; mem['h4B] = 8'h01;
    mem['h4C] = 8'h41;
    mem['h4D] = 8'hFF;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rdy_mode = 0; rst_drive = 1'b0; redir_tgt = 0;

    // S1: mixed lengths, ready always high (R2 R3 R4 R6)
    load_main(); do_reset(); build('h40, 1000); run(400);

    // S2: toggling ready (R7)
    rdy_mode = 1; load_main(); do_reset(); build('h40, 1000); run(400);

    // S3: long stall; reads must stop (R8)
    rdy_mode = 2; load_main(); do_reset(); build('h40, 1000);
    low_until = cyc + 25;
    for (int i = 0; i < 12; i++) step();
    chk(!mem_rd && ins_valid && ins_opcode == 8'hC0, "R8 reads stop while output blocked",
        int'(mem_rd), 0);
    run(400);

    // S4: alias 0x00, then redirect while stopped (R5 R10)
    rdy_mode = 0; clear_mem();
    mem['h40] = 8'hC0; mem['h41] = 8'h06; mem['h42] = 8'h01; mem['h43] = 8'h00;
    do_reset(); build('h40, 1000); run(200);
    redir_tgt = 'h90; redir_pend = 1'b1;
    step();
    for (int i = 0; i < 4; i++) step();
    chk(halted && !mem_rd, "R10 redirect ignored when stopped", int'(halted), 1);
    chk(int'(mem_addr) == 'h44, "R10 address frozen", int'(mem_addr), 'h44);

    // S5: alias 0x01 after a three-byte instruction (R5)
    clear_mem();
    mem['h40] = 8'h44; mem['h41] = 8'h00; mem['h42] = 8'h01; mem['h43] = 8'h01;
    do_reset(); build('h40, 1000); run(200);

    // S6: redirect between opcode and address bytes (R9)
    clear_mem();
    mem['h40] = 8'hC0; mem['h41] = 8'h44; mem['h42] = 8'h10; mem['h43] = 8'h20;
    mem['h80] = 8'h3E; mem['h81] = 8'h55; mem['h82] = 8'hC0; mem['h83] = 8'hFF;
    do_reset(); build('h40, 1); build('h80, 1000);
    redir_trig = 'h42; redir_tgt = 'h80;
    run(200);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule